// File: doc/BRIEF.md
# Soft-Symbol Depuncturer for a Rate-1/2 Trellis Decoder

The block sits in front of a Viterbi decoder. The transmitter removed some coded symbols to raise the code rate, and this block puts back the structure of the rate-1/2 mother code. It takes one received soft symbol per transfer. For every information-bit position it produces one pair of symbols (first code branch, second code branch). A position that the transmitter never sent comes out with its erasure flag set and a zero data field, so the decoder gives it no weight.

Seven rates are available: 1/2, 2/3, 3/4, 4/5, 5/6, 6/7 and 7/8. The rate is sampled on the transfer that carries the start-of-packet marker, and the block uses that rate until the next start of packet. Input and output are valid/ready streams that carry start and end markers. Each rate has a fixed two-row puncturing pattern. Column 0 is the leftmost character of each row, and the pattern repeats after as many columns as the rate numerator.

Top module: `depuncture_top`

## Requirements
- R1: After reset, out_valid is 0 and in_ready is 1.
- R2: rate_sel codes 0 to 6 select rates 1/2, 2/3, 3/4, 4/5, 5/6, 6/7 and 7/8, and code 7 behaves like code 0. The patterns (first row / second row, 1 = sent) are: 1/2 "1"/"1", 2/3 "10"/"11", 3/4 "101"/"110", 4/5 "1000"/"1111", 5/6 "10101"/"11010", 6/7 "100101"/"111010", 7/8 "1111010"/"1000101". Every output pair carries at least one real symbol.
- R3: Within a column, the first-branch symbol is taken from the input before the second-branch symbol. A column with both symbols sent takes two input transfers and produces its pair only after the second one.
- R4: A removed position is output with its erasure flag at 1 and its data field at 000. A sent position has its flag at 0 and carries the received value.
- R5: The rate is captured on the transfer that has in_sop=1. Changes on rate_sel during the rest of the packet have no effect on the output pairs.
- R6: Every start of packet restarts the pattern at column 0 and discards a half-collected pair left over from an earlier packet that ended without an end marker.
- R7: out_eop is set on the pair that consumes the last received symbol. If that symbol is the first-branch symbol of a two-symbol column, the pair is produced at once with the second branch erased.
- R8: out_sop is 1 on the first pair of a packet only, and that pair's first branch is never erased.
- R9: While out_valid=1 and out_ready=0, in_ready is 0 and the output pair stays unchanged.
- R10: After the last column of a pattern, the next pair uses column 0 again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rate_sel | input | 3 | Code rate select, sampled with in_sop |
| in_valid | input | 1 | Input symbol valid |
| in_ready | output | 1 | Block can take an input symbol |
| in_sym | input | SOFT_W (3) | Received soft symbol |
| in_sop | input | 1 | First symbol of a packet |
| in_eop | input | 1 | Last symbol of a packet |
| out_valid | output | 1 | Output pair valid |
| out_ready | input | 1 | Downstream takes the pair |
| out_ca | output | SOFT_W (3) | First-branch soft symbol |
| out_ca_erased | output | 1 | First branch was removed |
| out_cb | output | SOFT_W (3) | Second-branch soft symbol |
| out_cb_erased | output | 1 | Second branch was removed |
| out_sop | output | 1 | First pair of a packet |
| out_eop | output | 1 | Last pair of a packet |

## Verification
The assertions assume that each packet opens with an in_sop transfer. A symbol inside a packet can then never reach the block with a column index outside the pattern. They also assume that the downstream side keeps its own ready signal honest, so a pair that was not accepted must still be offered on the next cycle. The stimulus opens every packet with in_sop, keeps each input symbol and its markers stable until in_ready is seen high, and uses only nonzero symbol values so that an erased position can be told apart from a real one. Backpressure comes from a fixed out_ready pattern that sometimes stalls a pair for two or more cycles.

// File: rtl/depu_pkg.sv
package depu_pkg;
    localparam int RATE_W = 3;
    localparam int COL_W  = 3;
    localparam int MAX_COLS = 8;

    // Number of pattern columns for a rate code; code 7 falls back to rate 1/2.
    function automatic logic [COL_W-1:0] depu_period(input logic [RATE_W-1:0] r);
        logic [COL_W-1:0] p;
        if (r == RATE_W'(7)) p = COL_W'(1);
        else                 p = COL_W'(r) + COL_W'(1);
        return p;
    endfunction
endpackage

// File: rtl/depu_pattern.sv
module depu_pattern
    import depu_pkg::*;
(
    input  logic [RATE_W-1:0] rate,
    input  logic [COL_W-1:0]  col,
    output logic              take_ca,
    output logic              take_cb,
    output logic              last_col
);
    // Masks hold column c in bit c (the leftmost pattern character is bit 0).
    logic [MAX_COLS-1:0] mask_a;
    logic [MAX_COLS-1:0] mask_b;

    always_comb begin
        case (rate)
            3'd1:    begin mask_a = 8'b0000_0001; mask_b = 8'b0000_0011; end
            3'd2:    begin mask_a = 8'b0000_0101; mask_b = 8'b0000_0011; end
            3'd3:    begin mask_a = 8'b0000_0001; mask_b = 8'b0000_1111; end
            3'd4:    begin mask_a = 8'b0001_0101; mask_b = 8'b0000_1011; end
            3'd5:    begin mask_a = 8'b0010_1001; mask_b = 8'b0001_0111; end
            3'd6:    begin mask_a = 8'b0010_1111; mask_b = 8'b0101_0001; end
            default: begin mask_a = 8'b0000_0001; mask_b = 8'b0000_0001; end
        endcase
        take_ca  = mask_a[col];
        take_cb  = mask_b[col];
        last_col = (col == depu_period(rate) - COL_W'(1));
    end
endmodule

// File: rtl/depu_pair_reg.sv
module depu_pair_reg #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_data,
    input  logic         out_ready,
    output logic         out_valid,
    output logic [W-1:0] out_data,
    output logic         slot_free
);
    typedef struct packed {
        logic         valid;
        logic [W-1:0] data;
    } slot_t;

    slot_t slot_d, slot_q;

    always_comb begin
        slot_d = slot_q;
        if (load) begin
            slot_d.valid = 1'b1;
            slot_d.data  = load_data;
        end else if (out_ready) begin
            slot_d.valid = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) slot_q <= '0;
        else        slot_q <= slot_d;
    end

    assign out_valid = slot_q.valid;
    assign out_data  = slot_q.data;
    assign slot_free = !slot_q.valid || out_ready;

    // R9: a pair that was not taken is offered again without change.
    assert_hold_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
endmodule

// File: rtl/depuncture_top.sv
module depuncture_top
    import depu_pkg::*;
#(
    parameter int SOFT_W = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [RATE_W-1:0]   rate_sel,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [SOFT_W-1:0]   in_sym,
    input  logic                in_sop,
    input  logic                in_eop,
    output logic                out_valid,
    input  logic                out_ready,
    output logic [SOFT_W-1:0]   out_ca,
    output logic                out_ca_erased,
    output logic [SOFT_W-1:0]   out_cb,
    output logic                out_cb_erased,
    output logic                out_sop,
    output logic                out_eop
);
    typedef struct packed {
        logic              sop;
        logic              eop;
        logic              ca_era;
        logic [SOFT_W-1:0] ca;
        logic              cb_era;
        logic [SOFT_W-1:0] cb;
    } pair_t;

    localparam int PAIR_W = $bits(pair_t);

    typedef struct packed {
        logic [RATE_W-1:0] rate;
        logic [COL_W-1:0]  col;
        logic              have_ca;
        logic [SOFT_W-1:0] ca_sym;
        logic              sop_hold;
    } state_t;

    state_t st_d, st_q;

    logic              fire;
    logic              slot_free;
    logic [RATE_W-1:0] eff_rate;
    logic [COL_W-1:0]  eff_col;
    logic              eff_have;
    logic              take_ca, take_cb, last_col;
    logic              emit;
    pair_t             pair_new;
    logic [PAIR_W-1:0] pair_out;

    assign eff_rate = in_sop ? rate_sel : st_q.rate;
    assign eff_col  = in_sop ? '0 : st_q.col;
    assign eff_have = in_sop ? 1'b0 : st_q.have_ca;

    depu_pattern u_pattern (
        .rate     (eff_rate),
        .col      (eff_col),
        .take_ca  (take_ca),
        .take_cb  (take_cb),
        .last_col (last_col)
    );

    assign in_ready = slot_free;
    assign fire     = in_valid && in_ready;

    always_comb begin
        st_d     = st_q;
        emit     = 1'b0;
        pair_new = '0;
        if (fire) begin
            if (in_sop) st_d.rate = rate_sel;
            if (take_ca && take_cb && !eff_have && !in_eop) begin
                // first half of a two-symbol column: hold it
                st_d.have_ca  = 1'b1;
                st_d.ca_sym   = in_sym;
                st_d.sop_hold = in_sop;
                st_d.col      = eff_col;
            end else begin
                emit         = 1'b1;
                pair_new.eop = in_eop;
                if (take_ca && take_cb && eff_have) begin
                    pair_new.ca  = st_q.ca_sym;
                    pair_new.cb  = in_sym;
                    pair_new.sop = st_q.sop_hold;
                end else if (take_ca) begin
                    // single-symbol column, or packet ended on a first branch
                    pair_new.ca     = in_sym;
                    pair_new.cb_era = 1'b1;
                    pair_new.sop    = in_sop;
                end else begin
                    pair_new.ca_era = 1'b1;
                    pair_new.cb     = in_sym;
                    pair_new.sop    = in_sop;
                end
                st_d.have_ca  = 1'b0;
                st_d.sop_hold = 1'b0;
                st_d.col      = (last_col || in_eop) ? '0 : eff_col + COL_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    depu_pair_reg #(.W(PAIR_W)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (emit),
        .load_data (pair_new),
        .out_ready (out_ready),
        .out_valid (out_valid),
        .out_data  (pair_out),
        .slot_free (slot_free)
    );

    pair_t pair_view;
    assign pair_view     = pair_t'(pair_out);
    assign out_sop       = pair_view.sop;
    assign out_eop       = pair_view.eop;
    assign out_ca        = pair_view.ca;
    assign out_ca_erased = pair_view.ca_era;
    assign out_cb        = pair_view.cb;
    assign out_cb_erased = pair_view.cb_era;

    // R4: erased positions carry an all-zero data field.
    assert_erased_ca_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ca_erased) |-> (out_ca == '0));
    assert_erased_cb_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_cb_erased) |-> (out_cb == '0));
    // R2: no pair is made of two removed positions.
    assert_one_real_R2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !(out_ca_erased && out_cb_erased));
    // R8: the opening pair of a packet starts on a sent first branch.
    assert_sop_real_ca_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_sop) |-> !out_ca_erased);
    // R9: no input is taken while a pair waits on a stalled output.
    assert_stall_blocks_input_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready);
    // R10: the column index stays inside the pattern of the latched rate.
    assert_col_in_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.col < depu_period(st_q.rate));
endmodule

// File: tb/depuncture_top_bench.sv
`timescale 1ns/1ps
module depuncture_top_bench;
    localparam int SW = 3;
    localparam int PW = 2 * SW + 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [2:0]    rate_sel = '0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [SW-1:0] in_sym = '0;
    logic          in_sop = 1'b0;
    logic          in_eop = 1'b0;
    logic          out_valid;
    logic          out_ready = 1'b1;
    logic [SW-1:0] out_ca, out_cb;
    logic          out_ca_erased, out_cb_erased, out_sop, out_eop;

    always #2.5 clk = ~clk;

    depuncture_top #(.SOFT_W(SW)) u_depuncture_top (
        .clk(clk), .rst_n(rst_n), .rate_sel(rate_sel),
        .in_valid(in_valid), .in_ready(in_ready), .in_sym(in_sym),
        .in_sop(in_sop), .in_eop(in_eop),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_ca(out_ca), .out_ca_erased(out_ca_erased),
        .out_cb(out_cb), .out_cb_erased(out_cb_erased),
        .out_sop(out_sop), .out_eop(out_eop)
    );

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int rdy_mode = 0;

    string pat_a [7] = '{"1", "10", "101", "1000", "10101", "100101", "1111010"};
    string pat_b [7] = '{"1", "11", "110", "1111", "11010", "111010", "1000101"};

    logic [PW-1:0] obs [0:127];
    int            n_obs = 0;
    logic [PW-1:0] exp_v [0:127];
    int            n_exp = 0;

    logic          prev_stall = 1'b0;
    logic [PW-1:0] saved;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [SW-1:0] sym_of(input int i);
        return SW'((i % 7) + 1);
    endfunction

    // Output monitor plus the R9 stall check.
    always @(negedge clk) begin
        cyc++;
        out_ready = (rdy_mode == 0) ? 1'b1 : ((cyc % 4) >= 2);
        #1;
        if (rst_n) begin
            if (prev_stall) begin
                chk(out_valid && {out_sop, out_eop, out_ca_erased, out_ca, out_cb_erased, out_cb} == saved,
                    "R9", "pair held under stall",
                    int'({out_sop, out_eop, out_ca_erased, out_ca, out_cb_erased, out_cb}), int'(saved));
            end
            prev_stall = out_valid && !out_ready;
            if (prev_stall) begin
                saved = {out_sop, out_eop, out_ca_erased, out_ca, out_cb_erased, out_cb};
                chk(!in_ready, "R9", "in_ready low under stall", int'(in_ready), 0);
            end
            if (out_valid && out_ready && n_obs < 128) begin
                obs[n_obs] = {out_sop, out_eop, out_ca_erased, out_ca, out_cb_erased, out_cb};
                n_obs++;
            end
        end
    end

    // Independent model of the expected pairs.
    task automatic build_exp(input int r, input int n, input bit with_eop);
        int rr = (r == 7) ? 0 : r;
        int col = 0;
        int i = 0;
        n_exp = 0;
        while (i < n) begin
            bit a = (pat_a[rr][col] == 8'h31);
            bit b = (pat_b[rr][col] == 8'h31);
            logic [SW-1:0] ca = '0, cb = '0;
            bit cae = 1'b0, cbe = 1'b0, eop = 1'b0;
            if (a && b) begin
                if (i + 1 == n && !with_eop) break;
                ca = sym_of(i); i++;
                if (i == n) begin cbe = 1'b1; eop = 1'b1; end
                else begin cb = sym_of(i); i++; eop = with_eop && (i == n); end
            end else if (a) begin
                ca = sym_of(i); i++; cbe = 1'b1; eop = with_eop && (i == n);
            end else begin
                cb = sym_of(i); i++; cae = 1'b1; eop = with_eop && (i == n);
            end
            exp_v[n_exp] = {(n_exp == 0), eop, cae, ca, cbe, cb};
            n_exp++;
            col = (col + 1 == pat_a[rr].len() || eop) ? 0 : col + 1;
        end
    endtask

    task automatic send_packet(input int r, input int n, input bit with_eop,
                               input int later_rate);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_sym   = sym_of(i);
            in_sop   = (i == 0);
            in_eop   = with_eop && (i == n - 1);
            rate_sel = (i == 0) ? 3'(r) : 3'(later_rate);
            #1;
            while (!in_ready) begin @(negedge clk); #1; end
        end
        @(negedge clk);
        in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
    endtask

    task automatic compare(input string req, input string tag);
        repeat (30) @(negedge clk);
        chk(n_obs == n_exp, req, {tag, " pair count"}, n_obs, n_exp);
        for (int k = 0; k < n_exp && k < n_obs; k++)
            chk(obs[k] == exp_v[k], req, {tag, " pair"}, int'(obs[k]), int'(exp_v[k]));
    endtask

    task automatic t_reset;
        @(negedge clk); #1;
        chk(out_valid == 1'b0, "R1", "out_valid after reset", int'(out_valid), 0);
        chk(in_ready == 1'b1, "R1", "in_ready after reset", int'(in_ready), 1);
    endtask

    // R2 R3 R4 R7 R8 R10: every rate over two full pattern periods.
    task automatic t_all_rates;
        for (int r = 0; r < 8; r++) begin
            int rr = (r == 7) ? 0 : r;
            int per_syms = 0;
            for (int c = 0; c < pat_a[rr].len(); c++)
                per_syms += (pat_a[rr][c] == 8'h31) + (pat_b[rr][c] == 8'h31);
            n_obs = 0;
            build_exp(r, 2 * per_syms, 1'b1);
            send_packet(r, 2 * per_syms, 1'b1, r);
            compare("R2", "rate sweep");
        end
    endtask

    // R9: rate 6/7 under periodic backpressure.
    task automatic t_stall;
        rdy_mode = 1;
        n_obs = 0;
        build_exp(5, 14, 1'b1);
        send_packet(5, 14, 1'b1, 5);
        compare("R9", "stalled 6/7");
        rdy_mode = 0;
    endtask

    // R5: rate_sel moves after the start marker.
    task automatic t_rate_change;
        n_obs = 0;
        build_exp(4, 12, 1'b1);
        send_packet(4, 12, 1'b1, 0);
        compare("R5", "mid-packet rate change");
    endtask

    // R6: a half-collected pair is dropped by the next start of packet.
    task automatic t_restart;
        n_obs = 0;
        send_packet(1, 1, 1'b0, 1);
        build_exp(2, 6, 1'b1);
        send_packet(2, 6, 1'b1, 2);
        compare("R6", "restart after partial");
    endtask

    // R7: packet ends on a first-branch symbol of a two-symbol column.
    task automatic t_odd_end;
        n_obs = 0;
        build_exp(0, 3, 1'b1);
        send_packet(0, 3, 1'b1, 0);
        compare("R7", "end on first branch");
        chk(n_obs == 2 && obs[1][SW] == 1'b1 && obs[1][PW-2] == 1'b1, "R7",
            "last pair eop with erased second branch", int'(obs[1]), int'(exp_v[1]));
    endtask

    // R3: one two-symbol column gives no pair after its first symbol.
    task automatic t_two_transfers;
        n_obs = 0;
        @(negedge clk);
        in_valid = 1'b1; in_sym = 3'd5; in_sop = 1'b1; in_eop = 1'b0; rate_sel = 3'd6;
        @(negedge clk);
        in_valid = 1'b0; in_sop = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        chk(out_valid == 1'b0 && n_obs == 0, "R3", "no pair after first symbol", int'(out_valid), 0);
        in_valid = 1'b1; in_sym = 3'd6; in_eop = 1'b1;
        @(negedge clk);
        in_valid = 1'b0; in_eop = 1'b0;
        repeat (3) @(negedge clk);
        chk(n_obs == 1 && obs[0] == {1'b1, 1'b1, 1'b0, 3'd5, 1'b0, 3'd6}, "R3",
            "pair after second symbol", int'(obs[0]), int'({1'b1, 1'b1, 1'b0, 3'd5, 1'b0, 3'd6}));
    endtask

    task automatic finish_run;
        $display("  [TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_all_rates();
        t_stall();
        t_rate_change();
        t_restart();
        t_odd_end();
        t_two_transfers();
        finish_run();
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule